// File: doc/BRIEF.md
# Receive Burst Buffer Dispatcher

This block takes received burst data one beat at a time and places it into a pool of fixed-size receive buffers. A burst that fits in one buffer occupies one buffer. A longer burst is cut into several buffer-sized segments. A buffer is closed either when it becomes full or when the burst ends. At that point it gets a 64-bit control record: source port, first and last segment flags, byte length, checksum and segment number. The closed buffer is then queued for dispatch. The checksum is supplied from outside on the beat that closes the buffer. The data bytes themselves are stored elsewhere.

Worker threads register by pushing their IDs into a free-thread queue. Whenever a closed buffer and a free thread are both waiting, the oldest buffer goes to the oldest thread. The dispatch output carries the buffer index, the thread ID and the control record. Software gives buffers back through a release port.

The pool of 8192 bytes can be split into 128 buffers of 64 bytes, 64 of 128 bytes, or 32 of 256 bytes. The split can only be changed while every buffer is free.

The fill controller has three states:
- FS_IDLE: no burst in progress.
- FS_OPEN: a buffer is open and partly filled.
- FS_SPLIT: a burst is in progress, but its last buffer closed because it was full and no new buffer has been taken yet.

Transitions out of any state:
- A closing beat that carries end-of-packet goes to FS_IDLE.
- A closing beat without end-of-packet goes to FS_SPLIT.
- An accepted beat that does not close the buffer goes to FS_OPEN.

Top module: `rxbuf_dispatch`

## Requirements
- R1: After reset, dsp_valid is 0 and in_ready and thr_ready are both 1. The geometry is 64-byte buffers (code 0).
- R2: After reset, and after every accepted configuration change, buffers are handed out in ascending index order from 0. Released buffers are reused in the order they were released, after any never-used indices.
- R3: A burst no longer than the buffer size fills one buffer. Its record has first=1 and last=1, and its length equals the burst byte count.
- R4: A burst longer than the buffer size is split. Every segment except the last holds exactly one buffer size. The segment numbers count up from 0. Only the first segment has first=1 and only the last has last=1.
- R5: A buffer is dispatched as soon as it is full, without waiting for the end of its burst. With a free thread waiting, dsp_valid rises on the second clock edge after the closing beat is accepted.
- R6: Buffers are dispatched in the order they were closed. Thread IDs are used in the order they were registered.
- R7: While no thread is registered, closed buffers wait and dsp_valid stays 0. Registering a thread releases the oldest waiting buffer.
- R8: in_ready is 0 when no buffer is open and no free buffer remains. Beats are not accepted while in_ready is 0.
- R9: cfg_mode encodes the geometry: 0 = 64 bytes, 1 = 128 bytes, 2 = 256 bytes. Code 3 is ignored.
- R10: A cfg_load pulse takes effect only when no burst is in progress, no buffer is outstanding, and no beat is accepted in the same cycle. Otherwise it is ignored.
- R11: The record layout is:
  - bits 63:56: port
  - bits 55:50: zero
  - bit 49: last
  - bit 48: first
  - bits 47:32: byte length
  - bits 31:16: the in_csum value on the closing beat
  - bits 15:0: segment number
- R12: thr_ready is 0 while 16 thread IDs are queued. A thread push when thr_ready is 0 is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Request to change the geometry |
| cfg_mode | input | 2 | Requested geometry code |
| in_valid | input | 1 | Beat present |
| in_ready | output | 1 | Beat can be accepted |
| in_sop | input | 1 | Beat starts a burst |
| in_eop | input | 1 | Beat ends a burst |
| in_port | input | 8 | Port of the burst, taken on the start beat |
| in_nbytes | input | 5 | Valid bytes in the beat, 1 to 16 |
| in_csum | input | 16 | Checksum, recorded on the closing beat |
| rel_valid | input | 1 | Return a buffer to the pool |
| rel_idx | input | 7 | Index of the returned buffer |
| thr_valid | input | 1 | Register a free thread |
| thr_ready | output | 1 | Thread queue has room |
| thr_id | input | 5 | Thread ID |
| dsp_valid | output | 1 | Dispatch pulse |
| dsp_buf | output | 7 | Dispatched buffer index |
| dsp_thread | output | 5 | Receiving thread ID |
| dsp_rec | output | 64 | Control record |

## Verification
The assertions assume the following about the inputs:
- Every non-final beat of a burst carries 16 bytes, so a segment that is not last is exactly one buffer long.
- Only buffers that were actually dispatched are released, and each is released once, so the outstanding count stays within the pool.

The stimulus keeps to these rules. It builds bursts from full beats with only the final beat short, and it releases only indices it has seen on the dispatch port. It never pushes a thread while thr_ready is low, except where that very condition is under test.

// File: rtl/rxbd_pkg.sv
package rxbd_pkg;

    typedef struct packed {
        logic [7:0]  port;
        logic [5:0]  rsvd;
        logic        last;
        logic        first;
        logic [15:0] len;
        logic [15:0] csum;
        logic [15:0] seg;
    } rec_t;

    typedef enum logic [1:0] {
        GEO_64  = 2'd0,
        GEO_128 = 2'd1,
        GEO_256 = 2'd2,
        GEO_BAD = 2'd3
    } geo_e;

    typedef enum logic [1:0] {
        FS_IDLE  = 2'd0,
        FS_OPEN  = 2'd1,
        FS_SPLIT = 2'd2
    } fill_e;

endpackage

// File: rtl/rxbd_fifo.sv
module rxbd_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rd_ptr, wr_ptr;
    logic          do_push, do_pop;

    assign do_push = push && (count < CW'(DEPTH));
    assign do_pop  = pop && (count != '0);
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= wr_ptr + AW'(1);
            end
            if (do_pop) begin
                rd_ptr <= rd_ptr + AW'(1);
            end
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end
endmodule

// File: rtl/rxbd_alloc.sv
module rxbd_alloc #(
    parameter int NBUF_MAX = 128,
    localparam int IDX_W   = $clog2(NBUF_MAX),
    localparam int CW      = $clog2(NBUF_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_load,
    input  logic [1:0]       cfg_mode,
    input  logic             idle,
    input  logic             take,
    input  logic             rel_valid,
    input  logic [IDX_W-1:0] rel_idx,
    output logic             avail,
    output logic [IDX_W-1:0] alloc_idx,
    output logic [1:0]       cur_mode,
    output logic [CW-1:0]    out_cnt
);
    import rxbd_pkg::*;

    logic [CW-1:0]    nbuf;
    logic [CW-1:0]    fresh;
    logic             fresh_left;
    logic [IDX_W-1:0] ret_dout;
    logic [CW-1:0]    ret_cnt;
    logic             cfg_ok;

    assign nbuf       = CW'(NBUF_MAX) >> cur_mode;
    assign fresh_left = fresh < nbuf;
    assign avail      = fresh_left || (ret_cnt != '0);
    assign alloc_idx  = fresh_left ? fresh[IDX_W-1:0] : ret_dout;
    assign cfg_ok     = cfg_load && (cfg_mode != GEO_BAD) && idle
                        && (out_cnt == '0) && !take;

    rxbd_fifo #(.W(IDX_W), .DEPTH(NBUF_MAX)) u_ret (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cfg_ok),
        .push  (rel_valid),
        .din   (rel_idx),
        .pop   (take && !fresh_left),
        .dout  (ret_dout),
        .count (ret_cnt)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_mode <= GEO_64;
            fresh    <= '0;
            out_cnt  <= '0;
        end else begin
            if (cfg_ok) begin
                cur_mode <= cfg_mode;
                fresh    <= '0;
            end else if (take && fresh_left) begin
                fresh <= fresh + CW'(1);
            end
            out_cnt <= out_cnt + CW'(take) - CW'(rel_valid);
        end
    end
endmodule

// File: rtl/rxbd_fill.sv
module rxbd_fill #(
    parameter int IDX_W = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               in_sop,
    input  logic               in_eop,
    input  logic [7:0]         in_port,
    input  logic [4:0]         in_nbytes,
    input  logic [15:0]        in_csum,
    input  logic [15:0]        bsize,
    input  logic               avail,
    input  logic [IDX_W-1:0]   alloc_idx,
    output logic               in_ready,
    output logic               take,
    output logic               idle,
    output logic               push,
    output logic [IDX_W-1:0]   push_idx,
    output rxbd_pkg::rec_t     push_rec
);
    import rxbd_pkg::*;

    fill_e            st, nxt;
    logic [IDX_W-1:0] cur_idx;
    logic [15:0]      cur_len;
    logic [7:0]       cur_port;
    logic             cur_first;
    logic [15:0]      seg_no;

    logic             beat, opening, start, close;
    logic [IDX_W-1:0] this_idx;
    logic [15:0]      sum_len, this_seg;
    logic [7:0]       this_port;
    logic             this_first;

    always_comb begin
        opening    = (st != FS_OPEN);
        start      = in_sop && opening;
        this_idx   = opening ? alloc_idx : cur_idx;
        sum_len    = (opening ? 16'd0 : cur_len) + {11'd0, in_nbytes};
        this_port  = start ? in_port : cur_port;
        this_seg   = start ? 16'd0 : seg_no;
        this_first = start || (!opening && cur_first);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= FS_IDLE;
        end else begin
            st <= nxt;
        end
    end

    always_comb begin
        nxt      = st;
        in_ready = 1'b0;
        unique case (st)
            FS_IDLE:  in_ready = avail;
            FS_SPLIT: in_ready = avail;
            FS_OPEN:  in_ready = 1'b1;
            default:  in_ready = 1'b0;
        endcase
        beat     = in_valid && in_ready;
        close    = beat && (in_eop || (sum_len >= bsize));
        take     = beat && opening;
        idle     = (st == FS_IDLE);
        push     = close;
        push_idx = this_idx;
        push_rec = '{port: this_port, rsvd: 6'd0, last: in_eop,
                     first: this_first, len: sum_len, csum: in_csum,
                     seg: this_seg};
        if (beat) begin
            if (close && in_eop) begin
                nxt = FS_IDLE;
            end else if (close) begin
                nxt = FS_SPLIT;
            end else begin
                nxt = FS_OPEN;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_idx   <= '0;
            cur_len   <= '0;
            cur_port  <= '0;
            cur_first <= 1'b0;
            seg_no    <= '0;
        end else if (beat) begin
            cur_idx   <= this_idx;
            cur_len   <= sum_len;
            cur_port  <= this_port;
            cur_first <= this_first;
            seg_no    <= close ? this_seg + 16'd1 : this_seg;
        end
    end
endmodule

// File: rtl/rxbuf_dispatch.sv
module rxbuf_dispatch #(
    parameter int POOL_BYTES = 8192,
    parameter int MIN_BUF    = 64,
    parameter int THR_W      = 5,
    parameter int TQ_DEPTH   = 16,
    localparam int NBUF_MAX  = POOL_BYTES / MIN_BUF,
    localparam int IDX_W     = $clog2(NBUF_MAX),
    localparam int CW        = $clog2(NBUF_MAX + 1),
    localparam int TCW       = $clog2(TQ_DEPTH + 1),
    localparam int REC_W     = 64,
    localparam int DQ_W      = IDX_W + REC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_load,
    input  logic [1:0]       cfg_mode,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             in_sop,
    input  logic             in_eop,
    input  logic [7:0]       in_port,
    input  logic [4:0]       in_nbytes,
    input  logic [15:0]      in_csum,
    input  logic             rel_valid,
    input  logic [IDX_W-1:0] rel_idx,
    input  logic             thr_valid,
    output logic             thr_ready,
    input  logic [THR_W-1:0] thr_id,
    output logic             dsp_valid,
    output logic [IDX_W-1:0] dsp_buf,
    output logic [THR_W-1:0] dsp_thread,
    output logic [REC_W-1:0] dsp_rec
);
    import rxbd_pkg::*;

    logic             avail, take, idle, push;
    logic [IDX_W-1:0] alloc_idx, push_idx;
    logic [1:0]       cur_mode;
    logic [CW-1:0]    out_cnt;
    logic [15:0]      bsize;
    rec_t             push_rec;

    logic [DQ_W-1:0]  dq_dout;
    logic [CW-1:0]    dq_cnt;
    logic [THR_W-1:0] tq_dout;
    logic [TCW-1:0]   tq_cnt;
    logic             go;

    assign bsize     = 16'(MIN_BUF) << cur_mode;
    assign thr_ready = tq_cnt < TCW'(TQ_DEPTH);
    assign go        = (dq_cnt != '0) && (tq_cnt != '0);

    rxbd_alloc #(.NBUF_MAX(NBUF_MAX)) u_alloc (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_load  (cfg_load),
        .cfg_mode  (cfg_mode),
        .idle      (idle),
        .take      (take),
        .rel_valid (rel_valid),
        .rel_idx   (rel_idx),
        .avail     (avail),
        .alloc_idx (alloc_idx),
        .cur_mode  (cur_mode),
        .out_cnt   (out_cnt)
    );

    rxbd_fill #(.IDX_W(IDX_W)) u_fill (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sop    (in_sop),
        .in_eop    (in_eop),
        .in_port   (in_port),
        .in_nbytes (in_nbytes),
        .in_csum   (in_csum),
        .bsize     (bsize),
        .avail     (avail),
        .alloc_idx (alloc_idx),
        .in_ready  (in_ready),
        .take      (take),
        .idle      (idle),
        .push      (push),
        .push_idx  (push_idx),
        .push_rec  (push_rec)
    );

    rxbd_fifo #(.W(DQ_W), .DEPTH(NBUF_MAX)) u_doneq (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (1'b0),
        .push  (push),
        .din   ({push_idx, push_rec}),
        .pop   (go),
        .dout  (dq_dout),
        .count (dq_cnt)
    );

    rxbd_fifo #(.W(THR_W), .DEPTH(TQ_DEPTH)) u_thrq (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (1'b0),
        .push  (thr_valid),
        .din   (thr_id),
        .pop   (go),
        .dout  (tq_dout),
        .count (tq_cnt)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dsp_valid  <= 1'b0;
            dsp_buf    <= '0;
            dsp_thread <= '0;
            dsp_rec    <= '0;
        end else begin
            dsp_valid <= go;
            if (go) begin
                dsp_buf    <= dq_dout[DQ_W-1 -: IDX_W];
                dsp_rec    <= dq_dout[REC_W-1:0];
                dsp_thread <= tq_dout;
            end
        end
    end
endmodule

// File: rtl/rxbd_chk.sv
module rxbd_chk #(
    parameter int NBUF_MAX = 128,
    parameter int MIN_BUF  = 64,
    parameter int IDX_W    = 7,
    parameter int CW       = 8,
    parameter int TQ_DEPTH = 16,
    parameter int TCW      = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dsp_valid,
    input logic [IDX_W-1:0] dsp_buf,
    input logic [63:0]      dsp_rec,
    input logic [1:0]       mode,
    input logic [CW-1:0]    out_cnt,
    input logic [TCW-1:0]   tq_cnt
);
    import rxbd_pkg::*;

    rec_t r;
    assign r = dsp_rec;

    // R2
    buf_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dsp_valid |-> (int'(dsp_buf) < (NBUF_MAX >> mode)));

    // R4
    mid_seg_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dsp_valid && !r.last) |-> (int'(r.len) == (MIN_BUF << mode)));

    // R11
    rec_len_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dsp_valid |-> ((r.len != 16'd0) && (int'(r.len) <= (MIN_BUF << mode))));

    // R8
    out_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(out_cnt) <= (NBUF_MAX >> mode));

    // R10
    mode_change_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode) |-> ($past(out_cnt) == '0));

    // R9
    mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode != 2'd3);

    // R12
    thr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(tq_cnt) <= TQ_DEPTH);
endmodule

bind rxbuf_dispatch rxbd_chk #(
    .NBUF_MAX (NBUF_MAX),
    .MIN_BUF  (MIN_BUF),
    .IDX_W    (IDX_W),
    .CW       (CW),
    .TQ_DEPTH (TQ_DEPTH),
    .TCW      (TCW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dsp_valid (dsp_valid),
    .dsp_buf   (dsp_buf),
    .dsp_rec   (dsp_rec),
    .mode      (cur_mode),
    .out_cnt   (out_cnt),
    .tq_cnt    (tq_cnt)
);

// File: tb/test_rxbuf_dispatch.sv
module test_rxbuf_dispatch;
    import rxbd_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_load;
    logic [1:0]  cfg_mode;
    logic        in_valid, in_ready, in_sop, in_eop;
    logic [7:0]  in_port;
    logic [4:0]  in_nbytes;
    logic [15:0] in_csum;
    logic        rel_valid;
    logic [6:0]  rel_idx;
    logic        thr_valid, thr_ready;
    logic [4:0]  thr_id;
    logic        dsp_valid;
    logic [6:0]  dsp_buf;
    logic [4:0]  dsp_thread;
    logic [63:0] dsp_rec;

    always #10 clk = ~clk;

    rxbuf_dispatch i_rxbuf_dispatch (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_mode(cfg_mode),
        .in_valid(in_valid), .in_ready(in_ready), .in_sop(in_sop),
        .in_eop(in_eop), .in_port(in_port), .in_nbytes(in_nbytes),
        .in_csum(in_csum), .rel_valid(rel_valid), .rel_idx(rel_idx),
        .thr_valid(thr_valid), .thr_ready(thr_ready), .thr_id(thr_id),
        .dsp_valid(dsp_valid), .dsp_buf(dsp_buf), .dsp_thread(dsp_thread),
        .dsp_rec(dsp_rec)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // reference model state
    int          free_q[$];
    int          dq_buf[$];
    logic [63:0] dq_rec[$];
    int          tq[$];
    int          m_mode, m_out, m_idx, m_len, m_port, m_seg;
    bit          m_open, m_mid, m_first;
    bit          e_v;
    int          e_buf, e_thr;
    logic [63:0] e_rec;

    // observations
    int          obs_buf[$];
    int          obs_thr[$];
    logic [63:0] obs_rec[$];
    int          held[$];
    int          next_thr = 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic model_fill_pool();
        free_q.delete();
        for (int i = 0; i < (128 >> m_mode); i++) free_q.push_back(i);
    endtask

    task automatic tick(output bit acc);
        bit m_ready, thr_ok, pre_idle, start;
        int bsz, pre_out;
        rec_t r;
        #1;
        bsz      = 64 << m_mode;
        m_ready  = m_open || (free_q.size() > 0);
        thr_ok   = tq.size() < 16;
        pre_idle = !m_open && !m_mid;
        pre_out  = m_out;
        chk(in_ready === m_ready, "R8", "in_ready", 64'(in_ready), 64'(m_ready));
        chk(thr_ready === thr_ok, "R12", "thr_ready", 64'(thr_ready), 64'(thr_ok));
        if (dq_buf.size() > 0 && tq.size() > 0) begin
            e_v   = 1'b1;
            e_buf = dq_buf.pop_front();
            e_rec = dq_rec.pop_front();
            e_thr = tq.pop_front();
        end else begin
            e_v = 1'b0;
        end
        acc = in_valid && m_ready;
        if (acc) begin
            start = in_sop && !m_open;
            if (!m_open) begin
                m_idx   = free_q.pop_front();
                m_out++;
                m_len   = 0;
                m_first = start;
            end
            if (start) begin
                m_port = in_port;
                m_seg  = 0;
            end
            m_len += int'(in_nbytes);
            if (in_eop || m_len >= bsz) begin
                r = '{port: 8'(m_port), rsvd: 6'd0, last: in_eop, first: m_first,
                      len: 16'(m_len), csum: in_csum, seg: 16'(m_seg)};
                dq_buf.push_back(m_idx);
                dq_rec.push_back(r);
                m_open = 1'b0;
                m_mid  = !in_eop;
                m_seg++;
            end else begin
                m_open = 1'b1;
            end
        end
        if (rel_valid) begin
            free_q.push_back(int'(rel_idx));
            m_out--;
        end
        if (thr_valid && thr_ok) tq.push_back(int'(thr_id));
        if (cfg_load && cfg_mode != 2'd3 && pre_idle && pre_out == 0 && !acc) begin
            m_mode = int'(cfg_mode);
            model_fill_pool();
        end
        @(posedge clk);
        @(negedge clk);
        chk(dsp_valid === e_v, "R5/R7", "dsp_valid", 64'(dsp_valid), 64'(e_v));
        if (e_v && dsp_valid) begin
            chk(int'(dsp_buf) == e_buf, "R2", "dsp_buf", 64'(dsp_buf), 64'(e_buf));
            chk(int'(dsp_thread) == e_thr, "R6", "dsp_thread", 64'(dsp_thread), 64'(e_thr));
            chk(dsp_rec === e_rec, "R11", "dsp_rec", dsp_rec, e_rec);
        end
        if (dsp_valid) begin
            obs_buf.push_back(int'(dsp_buf));
            obs_thr.push_back(int'(dsp_thread));
            obs_rec.push_back(dsp_rec);
            held.push_back(int'(dsp_buf));
        end
    endtask

    task automatic step(input int n);
        bit a;
        repeat (n) tick(a);
    endtask

    task automatic send_beat(input bit sop, input bit eop, input int port,
                             input int nb, input int cs);
        bit a;
        in_valid  = 1'b1;
        in_sop    = sop;
        in_eop    = eop;
        in_port   = 8'(port);
        in_nbytes = 5'(nb);
        in_csum   = 16'(cs);
        do tick(a); while (!a);
        in_valid = 1'b0;
        in_sop   = 1'b0;
        in_eop   = 1'b0;
    endtask

    task automatic send_burst(input int port, input int bytes, input int cs);
        int rem = bytes;
        int i = 0;
        while (rem > 0) begin
            send_beat(i == 0, rem <= 16, port, (rem > 16) ? 16 : rem, cs + i);
            rem -= 16;
            i++;
        end
    endtask

    task automatic add_threads(input int n);
        for (int k = 0; k < n; k++) begin
            thr_valid = 1'b1;
            thr_id    = 5'(next_thr);
            next_thr  = (next_thr + 1) % 32;
            step(1);
        end
        thr_valid = 1'b0;
    endtask

    task automatic release_held();
        while (held.size() > 0) begin
            rel_valid = 1'b1;
            rel_idx   = 7'(held.pop_front());
            step(1);
        end
        rel_valid = 1'b0;
    endtask

    task automatic config_to(input int m);
        cfg_load = 1'b1;
        cfg_mode = 2'(m);
        step(1);
        cfg_load = 1'b0;
    endtask

    function automatic rec_t rec_at(input int i);
        return rec_t'(obs_rec[i]);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int base;
        rec_t r;
        rst_n = 1'b0; cfg_load = 1'b0; cfg_mode = 2'd0;
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_port = '0;
        in_nbytes = '0; in_csum = '0; rel_valid = 1'b0; rel_idx = '0;
        thr_valid = 1'b0; thr_id = '0;
        m_mode = 0; m_out = 0; m_open = 1'b0; m_mid = 1'b0; m_first = 1'b0;
        m_idx = 0; m_len = 0; m_port = 0; m_seg = 0; e_v = 1'b0;
        model_fill_pool();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(dsp_valid === 1'b0, "R1", "reset dsp_valid", 64'(dsp_valid), 0);
        chk(in_ready === 1'b1, "R1", "reset in_ready", 64'(in_ready), 1);
        chk(thr_ready === 1'b1, "R1", "reset thr_ready", 64'(thr_ready), 1);

        // R3: short burst in one buffer
        add_threads(4);
        base = obs_buf.size();
        send_burst(5, 48, 16'h1000);
        step(4);
        r = rec_at(base);
        chk(obs_buf[base] == 0, "R1", "first buffer index", 64'(obs_buf[base]), 0);
        chk(r.len == 16'd48 && r.first && r.last, "R3", "single buffer record",
            64'(r), 64'(48));

        // R4: 160 bytes split into 64/64/32
        base = obs_buf.size();
        send_burst(9, 160, 16'h2000);
        step(4);
        chk(obs_buf.size() == base + 3, "R4", "segment count",
            64'(obs_buf.size() - base), 3);
        for (int k = 0; k < 3; k++) begin
            r = rec_at(base + k);
            chk(int'(r.seg) == k, "R4", "segment number", 64'(r.seg), 64'(k));
            chk(r.len == ((k == 2) ? 16'd32 : 16'd64), "R4", "segment length",
                64'(r.len), (k == 2) ? 64'd32 : 64'd64);
            chk(r.first == (k == 0) && r.last == (k == 2), "R4", "segment flags",
                64'({r.first, r.last}), 64'({k == 0, k == 2}));
        end

        // R7: no thread, buffer waits
        base = obs_buf.size();
        send_burst(3, 32, 16'h3000);
        step(8);
        chk(obs_buf.size() == base, "R7", "dispatch without thread",
            64'(obs_buf.size() - base), 0);
        next_thr = 20;
        add_threads(1);
        step(3);
        chk(obs_buf.size() == base + 1 && obs_thr[base] == 20, "R6",
            "late thread id", 64'(obs_thr[obs_thr.size() - 1]), 20);

        // R10: config refused with buffers outstanding
        config_to(2);
        add_threads(2);
        base = obs_buf.size();
        send_burst(4, 96, 16'h4000);
        step(4);
        r = rec_at(base);
        chk(r.len == 16'd64, "R10", "geometry unchanged", 64'(r.len), 64);

        // R9: accepted config to 256-byte buffers restarts at index 0
        release_held();
        step(1);
        config_to(2);
        add_threads(2);
        base = obs_buf.size();
        send_burst(6, 200, 16'h5000);
        step(4);
        r = rec_at(base);
        chk(r.len == 16'd200 && r.first && r.last, "R9", "256-byte buffer",
            64'(r.len), 200);
        chk(obs_buf[base] == 0, "R2", "index restart", 64'(obs_buf[base]), 0);

        // R9: code 3 is ignored
        release_held();
        config_to(3);
        add_threads(2);
        base = obs_buf.size();
        send_burst(7, 300, 16'h6000);
        step(4);
        r = rec_at(base);
        chk(r.len == 16'd256, "R9", "code 3 ignored", 64'(r.len), 256);
        chk(obs_buf[base] == 1, "R2", "fresh index order", 64'(obs_buf[base]), 1);

        // R5: dispatch before end of burst
        release_held();
        config_to(0);
        add_threads(8);
        base = obs_buf.size();
        for (int b = 0; b < 31; b++) send_beat(b == 0, 1'b0, 8, 16, b);
        chk(obs_buf.size() > base, "R5", "dispatch before end of burst",
            64'(obs_buf.size() - base), 1);
        send_beat(1'b0, 1'b1, 8, 16, 31);
        step(4);
        chk(obs_buf.size() == base + 8, "R5", "all segments dispatched",
            64'(obs_buf.size() - base), 8);

        // R8: exhaust 32 buffers
        release_held();
        config_to(2);
        for (int b = 0; b < 32; b++) send_beat(1'b1, 1'b1, b, 16, b);
        in_valid = 1'b1; in_sop = 1'b1; in_eop = 1'b1; in_nbytes = 5'd16;
        #1;
        chk(in_ready === 1'b0, "R8", "pool exhausted", 64'(in_ready), 0);
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
        add_threads(16);
        step(20);
        add_threads(16);
        step(20);
        chk(obs_buf.size() == base + 8 + 32, "R6", "all waiting dispatched",
            64'(obs_buf.size()), 64'(base + 40));
        release_held();
        #1;
        chk(in_ready === 1'b1, "R8", "pool refilled", 64'(in_ready), 1);

        // R12: thread queue full
        add_threads(16);
        #1;
        chk(thr_ready === 1'b0, "R12", "thread queue full", 64'(thr_ready), 0);
        add_threads(1);
        step(2);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule